// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block is the digital timing core of a supply supervisor. A synchronized comparator flag reports whether the supply sits below its trip threshold. A free-running slow oscillator tick is the timebase. The block filters out short supply dips. It stretches reset after the supply recovers. It also debounces or extends manual resets that arrive on the shared active-low reset line. The block drives that line only through an open-drain pull-down enable, so other devices may share the line.

The reset line is bidirectional. Its sensed level is an input to the block. A falling edge made by another driver starts the same timeout as a supply recovery. The line then stays low for the timeout or for the external pulse, whichever is longer. Edges are taken only while the block's own driver is released, so the block never re-triggers on the low level it makes itself. A lockout flag for a companion nonvolatile memory is raised whenever the reset line is low, whatever drives it low.

All timing counts are in oscillator ticks. The default timeout is 1000 ticks, which at 5 kHz gives 200 ms. The default glitch filter needs 4 consecutive below-threshold samples.

Top module: `sup_reset_pulse_gen`

## Requirements
- R1: After `rst_n` is released, the block behaves as if the supply had been low, so `pin_pull_en` is 1. While the filtered supply fault is present, `pin_pull_en` stays 1.
- R2: The first tick that samples `supply_low`=0 clears the fault. After that, `pin_pull_en` is still 1 after TIMEOUT_TICKS-1 further ticks and is 0 after exactly TIMEOUT_TICKS further ticks.
- R3: A run of fewer than GLITCH_SAMPLES consecutive ticks with `supply_low`=1 has no effect on `pin_pull_en`. The GLITCH_SAMPLES-th consecutive low sample sets `pin_pull_en`=1 one clock after that tick.
- R4: A qualifying dip that occurs during a running timeout restarts the timeout from zero. The full TIMEOUT_TICKS are then counted from the next high sample.
- R5: A falling edge of `pin_sense` (1 in one clock, 0 in the next) while `pin_pull_en`=0 sets `pin_pull_en`=1 on the following clock. The pull is held for TIMEOUT_TICKS ticks, even when the external low lasts only one clock.
- R6: An external low longer than the timeout ends the block's pull after TIMEOUT_TICKS ticks. `nvm_lock` stays 1 until `pin_sense` returns to 1. Releasing the pull onto a still-low line does not start a new timeout.
- R7: While `pin_pull_en`=1, external pulses on the line neither restart nor extend the running timeout. The line's own low level is never taken as an edge.
- R8: `nvm_lock` is 1 whenever `pin_pull_en` is 1 or `pin_sense` is 0. Otherwise it is 0.
- R9: A supply fault that occurs during a manual reset takes over. After the supply recovers, the full TIMEOUT_TICKS are counted from the first high sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset of the logic |
| osc_tick | input | 1 | One-clock pulse per oscillator period (timebase) |
| supply_low | input | 1 | Synchronized comparator flag, 1 = supply below trip point |
| pin_sense | input | 1 | Synchronized level of the shared reset line, 0 = low |
| pin_pull_en | output | 1 | Open-drain pull-down enable for the reset line |
| nvm_lock | output | 1 | Nonvolatile write lockout, 1 = writes blocked |

## Verification
A timer that holds the wrong count shows up at `pin_pull_en` as a release one or more ticks too early or too late. For that reason the bench samples the output in the tick just before the expected release and in the tick of the release. A glitch counter that is not cleared by a high sample turns two short dips into one qualifying dip, and `pin_pull_en` rises one clock after the offending tick. An edge detector that misses the driver gate re-triggers when the block releases a line that is still held low, and the stuck pull is visible within one clock of the release.

// File: rtl/sup_pkg.sv
package sup_pkg;
  // saturating increment used by the glitch counter
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // true when a below-threshold sample completes a qualifying run
  function automatic bit run_qualifies(input int unsigned prev_run, input int unsigned need);
    return (prev_run + 1) >= need;
  endfunction

  // true when the timeout counter holds its terminal value
  function automatic bit timeout_done(input int unsigned cnt, input int unsigned limit);
    return cnt == limit - 1;
  endfunction
endpackage

// File: rtl/sup_glitch_filter.sv
module sup_glitch_filter #(
  parameter int unsigned GLITCH_SAMPLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic supply_low,
  output logic fault
);
  import sup_pkg::*;
  localparam int unsigned GW = $clog2(GLITCH_SAMPLES + 1);
  localparam logic [GW-1:0] LAST_RUN = GW'(GLITCH_SAMPLES - 1);

  logic [GW-1:0] run_q;
  logic          fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= LAST_RUN;
      fault_q <= 1'b1;
    end else if (osc_tick) begin
      if (supply_low) begin
        run_q   <= GW'(sat_inc(32'(run_q), GLITCH_SAMPLES));
        fault_q <= fault_q | run_qualifies(32'(run_q), GLITCH_SAMPLES);
      end else begin
        run_q   <= '0;
        fault_q <= 1'b0;
      end
    end
  end

  assign fault = fault_q;

  AST_FAULT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> $past(osc_tick && supply_low && run_q == LAST_RUN)); // R3
  AST_HIGH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_tick && !supply_low) |=> !fault_q); // R2
endmodule

// File: rtl/sup_pin_edge.sv
module sup_pin_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_sense,
  input  logic pull_active,
  output logic ext_edge
);
  logic sense_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sense_q <= 1'b0;
    else        sense_q <= pin_sense;
  end

  // leading edge only, and only while our own driver is off
  assign ext_edge = sense_q & ~pin_sense & ~pull_active;
endmodule

// File: rtl/sup_reset_timer.sv
module sup_reset_timer #(
  parameter int unsigned TIMEOUT_TICKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic fault,
  input  logic ext_edge,
  output logic active
);
  import sup_pkg::*;
  localparam int unsigned CW = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(TIMEOUT_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (fault || ext_edge) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q && osc_tick) begin
      if (timeout_done(32'(cnt_q), TIMEOUT_TICKS)) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active = active_q;

  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> active_q); // R1
  AST_FULL_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> $past(cnt_q == LAST_CNT && osc_tick && !fault)); // R2
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_CNT); // R4
  AST_EDGE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    ext_edge |=> (active_q && cnt_q == '0)); // R5
endmodule

// File: rtl/sup_reset_pulse_gen.sv
module sup_reset_pulse_gen #(
  parameter int unsigned TIMEOUT_TICKS  = 1000,
  parameter int unsigned GLITCH_SAMPLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic supply_low,
  input  logic pin_sense,
  output logic pin_pull_en,
  output logic nvm_lock
);
  logic fault;
  logic ext_edge;
  logic pull_active;

  sup_glitch_filter #(.GLITCH_SAMPLES(GLITCH_SAMPLES)) u_filt (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
    .supply_low(supply_low), .fault(fault));

  sup_pin_edge u_edge (
    .clk(clk), .rst_n(rst_n), .pin_sense(pin_sense),
    .pull_active(pull_active), .ext_edge(ext_edge));

  sup_reset_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
    .fault(fault), .ext_edge(ext_edge), .active(pull_active));

  assign pin_pull_en = pull_active;
  assign nvm_lock    = pull_active | ~pin_sense;

  AST_NO_SELF_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pull_en && !fault) |=> !($past(pin_pull_en) && !pin_pull_en && ext_edge)); // R7
  AST_LOCK_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (fault || ext_edge) |=> nvm_lock); // R8
endmodule

// File: tb/sim_sup_reset_pulse_gen.sv
module sim_sup_reset_pulse_gen;
  localparam int CLK_PERIOD = 10;
  localparam int T = 20;
  localparam int G = 3;

  typedef struct {
    string req;
    logic  pull;
    logic  lock;
  } exp_t;

  logic clk = 0, rst_n = 0, osc_tick = 0, supply_low = 1, ext_low = 0;
  logic pin_pull_en, nvm_lock, pin_sense;
  int   n_checks = 0, n_fail = 0;
  bit   finished = 0;
  exp_t q[$];

  // open-drain line model: low if anyone pulls it
  assign pin_sense = !(pin_pull_en | ext_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  sup_reset_pulse_gen #(.TIMEOUT_TICKS(T), .GLITCH_SAMPLES(G)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .supply_low(supply_low),
    .pin_sense(pin_sense), .pin_pull_en(pin_pull_en), .nvm_lock(nvm_lock));

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) osc_tick = 1;
      @(negedge clk) osc_tick = 0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic expect_out(input string req, input logic pull, input logic lock);
    exp_t e;
    e.req = req; e.pull = pull; e.lock = lock;
    q.push_back(e);
    wait (q.size() == 0);
  endtask

  // monitor: pops expectations and compares away from clock edges
  initial begin
    forever begin
      exp_t e;
      wait (q.size() != 0);
      #1;
      e = q.pop_front();
      n_checks++;
      if (pin_pull_en !== e.pull || nvm_lock !== e.lock) begin
        n_fail++;
        $display("FAIL %s: pull=%b lock=%b expected pull=%b lock=%b",
                 e.req, pin_pull_en, nvm_lock, e.pull, e.lock);
      end
    end
  end

  task automatic recover(input string req);
    supply_low = 0;
    ticks(T);
    expect_out(req, 1, 1);
    ticks(1);
    expect_out(req, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_out("R1", 1, 1);              // reset state
    rst_n = 1;
    ticks(4);
    expect_out("R1", 1, 1);              // supply still low
    recover("R2");                       // full timeout from first high sample

    // R3: short dip ignored, then qualifying dip
    supply_low = 1; ticks(G-1);
    expect_out("R3", 0, 0);
    supply_low = 0; ticks(1);
    supply_low = 1; ticks(G-1);
    expect_out("R3", 0, 0);
    ticks(1);
    expect_out("R3", 1, 1);

    // R4: qualifying dip during timeout restarts it
    supply_low = 0; ticks(11);
    expect_out("R4", 1, 1);
    supply_low = 1; ticks(G);
    expect_out("R4", 1, 1);
    recover("R4");

    // R5: one-clock external pulse is stretched to the timeout
    @(negedge clk) ext_low = 1;
    @(negedge clk) ext_low = 0;
    expect_out("R5", 1, 1);
    ticks(5);
    // R7: external pulse while driving does not restart the timer
    @(negedge clk) ext_low = 1;
    @(negedge clk) ext_low = 0;
    ticks(T-6);
    expect_out("R7", 1, 1);
    ticks(1);
    expect_out("R7", 0, 0);
    ticks(3);
    expect_out("R7", 0, 0);

    // R6: long external pulse outlasts the timeout
    @(negedge clk) ext_low = 1;
    ticks(T);
    expect_out("R6", 0, 1);
    ticks(5);
    expect_out("R6", 0, 1);
    @(negedge clk) ext_low = 0;
    expect_out("R8", 0, 0);
    ticks(2);
    expect_out("R6", 0, 0);

    // R9: supply fault during a manual reset takes over
    @(negedge clk) ext_low = 1;
    @(negedge clk) ext_low = 0;
    ticks(3);
    supply_low = 1; ticks(G);
    expect_out("R9", 1, 1);
    ticks(T);
    expect_out("R9", 1, 1);
    recover("R9");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule